// File: doc/BRIEF.md
# Nine-Bit Flagged Command Serializer

This block takes one display-controller command at a time and sends it to a panel over a serial link that only writes. A command is an 8-bit opcode followed by zero, one or two 8-bit parameters. Each byte on the wire is preceded by a flag bit: 0 marks the opcode and 1 marks a parameter. The flagged 9-bit words are joined MSB-first and left-aligned. The tail is then filled with zero bits up to a whole number of bytes, and the result is clocked out inside its own chip-select frame.

The host offers a command on a valid/ready handshake that carries the opcode, a two-bit parameter count and both parameter bytes. The serial clock is derived from the system clock by an even divide ratio. Between frames the chip select stays high for a fixed gap, and no new command is taken during that gap. A one-cycle completion pulse marks the end of each frame.

Top module: `nine_bit_cmd_framer`

## Requirements
- R1: The first 9 bits of every frame are a 0 flag bit followed by the opcode, most significant bit first.
- R2: Each parameter follows as a 1 flag bit and then its 8 bits MSB-first: first `cmd_p0` (count 1 or 2), then `cmd_p1` (count 2 only).
- R3: A command with count value 3 completes the handshake but sends nothing. Chip select stays high, no completion pulse is raised, and the next command is framed normally.
- R4: A frame has exactly 8×(count+2) clock pulses: 16, 24 or 32. The bits after the last flagged word are zero.
- R5: The serial clock is high whenever chip select is high and at the moment chip select falls or rises. Data changes only while the clock is low, so every rising edge samples stable data.
- R6: While chip select is low, consecutive rising edges of the serial clock are exactly `DIV` system clocks apart.
- R7: `cmd_ready` is low for the whole frame and for exactly 2×`DIV` system clocks after chip select rises, and then returns high.
- R8: `done` is high for exactly one system clock per sent frame: the first clock in which chip select is high again.
- R9: After reset, chip select and the serial clock are high, `done` is low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high together with valid |
| cmd_op | input | 8 | Opcode byte |
| cmd_nparm | input | 2 | Parameter count; 0, 1 or 2 are sent, 3 is dropped |
| cmd_p0 | input | 8 | First parameter byte |
| cmd_p1 | input | 8 | Second parameter byte |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Active-low chip select, one low frame per command |
| done | output | 1 | One-cycle pulse at the end of each frame |

## Verification
Commands are sent with each of the three parameter counts, so the 16-, 24- and 32-pulse frame lengths and their different padding widths are each seen. All-zero and all-one bytes are included: with all-zero data the flag bits are the only ones on the wire, and with all-one data the padding zeros stand out. A dropped count-3 command is placed between two valid ones to show that it leaves no frame and does not disturb the one after it. A back-to-back burst with valid held high exercises the inter-frame gap and the ready timing.

// File: rtl/nine_bit_cmd_framer.sv
module nine_bit_cmd_framer #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_op,
  input  logic [1:0] cmd_nparm,
  input  logic [7:0] cmd_p0,
  input  logic [7:0] cmd_p1,
  output logic       spi_sclk,
  output logic       spi_mosi,
  output logic       spi_cs_n,
  output logic       done
);
  localparam int HALF = DIV / 2;
  localparam int GAP  = 2 * DIV;
  localparam int CW   = $clog2(GAP + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [5:0]   sent, total;
  logic [31:0]  sr, frame;
  logic         take;

  initial begin
    if (DIV < 2 || DIV % 2 != 0) $error("DIV must be even and at least 2");
  end

  assign cmd_ready = (st == S_IDLE);
  assign take      = cmd_valid && cmd_ready && (cmd_nparm != 2'd3);
  assign spi_mosi  = sr[31];
  assign frame     = {1'b0, cmd_op,
                      (cmd_nparm != 2'd0) ? {1'b1, cmd_p0} : 9'd0,
                      (cmd_nparm == 2'd2) ? {1'b1, cmd_p1} : 9'd0,
                      5'd0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      sent     <= '0;
      total    <= '0;
      sr       <= '0;
      spi_sclk <= 1'b1;
      spi_cs_n <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (take) begin
            st       <= S_SHIFT;
            sr       <= frame;
            total    <= {({1'b0, cmd_nparm} + 3'd2), 3'b000};
            sent     <= '0;
            cnt      <= '0;
            spi_cs_n <= 1'b0;
          end
        end
        S_SHIFT: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            if (spi_sclk) begin
              if (sent == total) begin
                spi_cs_n <= 1'b1;
                done     <= 1'b1;
                sr       <= '0;
                st       <= S_GAP;
              end else begin
                spi_sclk <= 1'b0;
                if (sent != 6'd0) sr <= {sr[30:0], 1'b0};
              end
            end else begin
              spi_sclk <= 1'b1;
              sent     <= sent + 6'd1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CW'(GAP - 1)) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assert_drop_bad_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_nparm == 2'd3) |=> (spi_cs_n && cmd_ready));

  assert_clock_idles_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_sclk);

  assert_data_stable_at_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> $stable(spi_mosi));

  assert_no_accept_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !cmd_ready);

  assert_done_at_cs_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && $past(!spi_cs_n)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_nine_bit_cmd_framer.sv
module tb_nine_bit_cmd_framer;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_op = '0, cmd_p0 = '0, cmd_p1 = '0;
  logic [1:0] cmd_nparm = '0;
  logic cmd_ready, spi_sclk, spi_mosi, spi_cs_n, done;

  nine_bit_cmd_framer #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_nparm(cmd_nparm), .cmd_p0(cmd_p0), .cmd_p1(cmd_p1),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int exp_len[$];
  logic [31:0] exp_val[$];
  int frames_started = 0, done_count = 0, frames_sent = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] expect_frame(input logic [7:0] op, input int n,
                                               input logic [7:0] p0, input logic [7:0] p1);
    logic [8:0] w [3];
    logic [31:0] v = '0;
    int pos = 31;
    w[0] = {1'b0, op};
    w[1] = {1'b1, p0};
    w[2] = {1'b1, p1};
    for (int k = 0; k <= n; k++)
      for (int b = 8; b >= 0; b--) begin
        v[pos] = w[k][b];
        pos--;
      end
    return v;
  endfunction

  task automatic send(input logic [7:0] op, input int n, input logic [7:0] p0, input logic [7:0] p1);
    if (n < 3) begin
      exp_len.push_back(8 * (n + 2));
      exp_val.push_back(expect_frame(op, n, p0, p1));
      frames_sent++;
    end
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_nparm = 2'(n);
    cmd_p0 = p0;
    cmd_p1 = p1;
    forever begin
      if (cmd_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_len.size() != 0 || !cmd_ready) @(negedge clk);
  endtask

  initial begin : monitor
    logic prev_cs = 1'b1, prev_sclk = 1'b1;
    int nb = 0, cyc = 0, last_rise = 0, gap_cnt = 0;
    bit in_gap = 0;
    logic [31:0] got = '0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      cyc++;
      if (done) done_count++;
      if (!spi_cs_n && prev_cs) begin
        check(spi_sclk == 1'b1, "R5", "sclk at cs fall", spi_sclk, 1);
        nb = 0;
        got = '0;
        frames_started++;
      end
      if (!spi_cs_n) begin
        if (cmd_ready) check(0, "R7", "ready during frame", 1, 0);
        if (spi_sclk && !prev_sclk) begin
          if (nb < 32) got[31-nb] = spi_mosi;
          if (nb > 0) check(cyc - last_rise == DIV, "R6", "sclk period", cyc - last_rise, DIV);
          last_rise = cyc;
          nb++;
        end
      end
      if (spi_cs_n && !prev_cs) begin
        check(done == 1'b1, "R8", "done at cs rise", done, 1);
        check(spi_sclk == 1'b1, "R5", "sclk at cs rise", spi_sclk, 1);
        if (exp_len.size() == 0) begin
          check(0, "R3", "unexpected frame", got, 0);
        end else begin
          int el;
          logic [31:0] ev;
          el = exp_len.pop_front();
          ev = exp_val.pop_front();
          check(nb == el, "R4", "pulse count", nb, el);
          check(got == ev, "R1 R2", "frame bits", got, ev);
        end
        in_gap = 1;
        gap_cnt = 0;
      end else if (done) begin
        check(0, "R8", "done without cs rise", 1, 0);
      end
      if (spi_cs_n && in_gap) begin
        if (cmd_ready) begin
          check(gap_cnt == 2 * DIV, "R7", "gap length", gap_cnt, 2 * DIV);
          in_gap = 0;
        end else gap_cnt++;
      end
      prev_cs = spi_cs_n;
      prev_sclk = spi_sclk;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(0, "R6", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    int started;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(spi_cs_n == 1'b1, "R9", "cs after reset", spi_cs_n, 1);
    check(spi_sclk == 1'b1, "R9", "sclk after reset", spi_sclk, 1);
    check(cmd_ready == 1'b1, "R9", "ready after reset", cmd_ready, 1);
    check(done == 1'b0, "R9", "done after reset", done, 0);

    send(8'h01, 0, 8'h00, 8'h00); wait_idle();   // R1 opcode only
    send(8'hB0, 1, 8'h16, 8'h00); wait_idle();   // R2 one parameter
    send(8'hB8, 2, 8'hFF, 8'hF9); wait_idle();   // R2 two parameters
    send(8'h00, 2, 8'h00, 8'h00); wait_idle();   // R2 flags alone
    send(8'hFF, 0, 8'hFF, 8'hFF); wait_idle();   // R4 padding zeros

    started = frames_started;                     // R3 dropped count
    send(8'hAA, 3, 8'h55, 8'h66);
    repeat (20) begin
      @(negedge clk);
      check(spi_cs_n == 1'b1, "R3", "cs high after drop", spi_cs_n, 1);
    end
    check(frames_started == started, "R3", "no frame after drop", frames_started, started);
    send(8'h29, 1, 8'h3C, 8'h00); wait_idle();   // R3 next one intact

    for (int i = 0; i < 9; i++)                   // R7 back-to-back burst
      send(8'(8'h11 * i + 3), i % 3, 8'(8'h5A ^ i), 8'(8'hC3 + i));
    wait_idle();
    repeat (4 * DIV) @(negedge clk);
    check(done_count == frames_sent, "R8", "done pulse count", done_count, frames_sent);
    check(frames_started == frames_sent, "R4", "frame count", frames_started, frames_sent);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule